// File: doc/BRIEF.md
# Decimal Fibonacci Term Engine

This block produces the Fibonacci sequence in decimal form, one new term per tick strobe. It keeps three banks of 4-bit digits: the two older terms and the term on display. On each accepted tick it moves the terms down one bank and then forms the new display term. It adds the two older terms one digit per clock cycle, lowest digit first, and applies a decimal correction to every digit.

A display refresher may read any digit of the display bank through a combinational read port at any time. A valid flag shows when that bank holds a finished term. If the newest sum overflows the most significant digit, the engine returns to its starting pair (0 and 1) and shows 1 again. A synchronous active-high reset clears all banks and starts the same sequence.

Top module: `fib_bcd_engine`

## Requirements
- R1: While `rst` is high, `disp_valid` is 0 and every display digit reads 0. After reset is released, the engine loads 0 into the first older bank and 1 into the second, and its first displayed term is 1.
- R2: Each digit is the binary sum of the two older digits and the incoming carry. A sum of 0 to 9 is stored unchanged with outgoing carry 0. A sum of 10 to 19 is stored as the low four bits of sum+6 with outgoing carry 1. Digit 0 starts with carry 0.
- R3: Successive displayed terms follow 1, 2, 3, 5, 8, 13, 21, ..., each being the sum of the two terms before it, in packed decimal.
- R4: `disp_valid` drops in the cycle after an accepted tick. It stays low for DIGITS+1 cycles: one cycle to move the banks down and DIGITS cycles for the digit-serial add. It then returns high. After reset release it stays low for DIGITS+1 cycles, counting the cycle in which `rst` is sampled low.
- R5: A tick that arrives while `disp_valid` is low has no effect. The term shown afterwards and the timing of `disp_valid` are the same as if it had not arrived.
- R6: While `disp_valid` is high and no tick arrives, `disp_valid` stays high and the display digits do not change.
- R7: When the sum of the two older terms produces a carry out of digit DIGITS-1, the engine reloads 0 and 1, repeats the add, and displays 1. `disp_valid` stays low for 2*(DIGITS+1) cycles in this case.
- R8: `rd_digit` returns display digit `rd_idx` combinationally. Digit 0 is the least significant digit, at bits [3:0] of the packed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Advance strobe, one cycle wide |
| rd_idx | input | $clog2(DIGITS) | Display digit index, 0 is least significant |
| rd_digit | output | NIB | Display bank digit at `rd_idx` |
| disp_valid | output | 1 | Display bank holds a finished term |

## Verification
Two functions can fall in the same cycle: the digit-serial add and the arrival of a new tick. The bench forces this overlap by pulsing a second tick two cycles into an add. It then checks that the valid window closes at its normal time and that the term shown is the one the first tick produced, not a skipped one. Overflow restart and a new term also meet in one pass: the add that overflows is followed at once by reload and a second add. The bench judges this by the longer low window and the displayed value 1.

// File: rtl/fib_bcd_pkg.sv
package fib_bcd_pkg;
   typedef enum logic [1:0] {
      ST_LOAD  = 2'd0,
      ST_SUM   = 2'd1,
      ST_SHOW  = 2'd2,
      ST_SLIDE = 2'd3
   } fib_state_e;

   localparam int DEC_RADIX = 10;
   localparam int DEC_FIX   = 6;
endpackage

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder #(
   parameter int NIB         = 4,
   parameter int ADJ_VARIANT = 0
) (
   input  logic [NIB-1:0] a_dig,
   input  logic [NIB-1:0] b_dig,
   input  logic           c_in,
   output logic [NIB-1:0] s_dig,
   output logic           c_out
);
   import fib_bcd_pkg::*;
   localparam int W = NIB + 1;

   logic [W-1:0] raw;
   logic [W-1:0] fixed;

   assign raw   = {1'b0, a_dig} + {1'b0, b_dig} + W'(c_in);
   assign fixed = raw + W'(DEC_FIX);

   generate
      if (ADJ_VARIANT == 0) begin : g_compare
         // single magnitude compare on the five-bit sum
         always_comb begin
            if (raw >= W'(DEC_RADIX)) begin
               s_dig = fixed[NIB-1:0];
               c_out = 1'b1;
            end else begin
               s_dig = raw[NIB-1:0];
               c_out = 1'b0;
            end
         end
      end else begin : g_two_path
         // binary carry path and 10..15 path handled separately
         logic in_hex_range;
         assign in_hex_range = raw[NIB-1] & (raw[NIB-2] | raw[NIB-3]);
         always_comb begin
            if (raw[NIB]) begin
               s_dig = fixed[NIB-1:0];
               c_out = 1'b1;
            end else if (in_hex_range) begin
               s_dig = fixed[NIB-1:0];
               c_out = 1'b1;
            end else begin
               s_dig = raw[NIB-1:0];
               c_out = 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fib_seq_ctrl.sv
module fib_seq_ctrl #(
   parameter  int DIGITS = 16,
   localparam int IDXW   = $clog2(DIGITS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            tick,
   input  logic            dig_carry,
   output logic            do_load,
   output logic            do_sum,
   output logic            do_slide,
   output logic [IDXW-1:0] pos,
   output logic            carry_q,
   output logic            show
);
   import fib_bcd_pkg::*;
   localparam logic [IDXW-1:0] LAST = IDXW'(DIGITS - 1);

   fib_state_e state;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_LOAD;
         pos     <= '0;
         carry_q <= 1'b0;
      end else begin
         case (state)
            ST_LOAD: begin
               state   <= ST_SUM;
               pos     <= '0;
               carry_q <= 1'b0;
            end
            ST_SUM: begin
               carry_q <= dig_carry;
               if (pos == LAST) begin
                  pos   <= '0;
                  state <= dig_carry ? ST_LOAD : ST_SHOW;
               end else begin
                  pos <= pos + 1'b1;
               end
            end
            ST_SHOW: begin
               if (tick) state <= ST_SLIDE;
            end
            default: begin
               state   <= ST_SUM;
               pos     <= '0;
               carry_q <= 1'b0;
            end
         endcase
      end
   end

   assign do_load  = (state == ST_LOAD);
   assign do_sum   = (state == ST_SUM);
   assign do_slide = (state == ST_SLIDE);
   assign show     = (state == ST_SHOW);
endmodule

// File: rtl/fib_bank_regs.sv
module fib_bank_regs #(
   parameter  int DIGITS = 16,
   parameter  int NIB    = 4,
   localparam int IDXW   = $clog2(DIGITS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            do_load,
   input  logic            do_slide,
   input  logic            do_sum,
   input  logic [IDXW-1:0] pos,
   input  logic [NIB-1:0]  sum_dig,
   output logic [NIB-1:0]  old_a,
   output logic [NIB-1:0]  old_b,
   input  logic [IDXW-1:0] view_idx,
   output logic [NIB-1:0]  view_dig
);
   logic [DIGITS-1:0][NIB-1:0] bank_a;
   logic [DIGITS-1:0][NIB-1:0] bank_b;
   logic [DIGITS-1:0][NIB-1:0] bank_v;

   genvar gi;
   generate
      for (gi = 0; gi < DIGITS; gi++) begin : g_digit
         localparam logic [NIB-1:0] SEED = (gi == 0) ? NIB'(1) : '0;
         always_ff @(posedge clk) begin
            if (rst) begin
               bank_a[gi] <= '0;
               bank_b[gi] <= '0;
               bank_v[gi] <= '0;
            end else if (do_load) begin
               bank_a[gi] <= '0;
               bank_b[gi] <= SEED;
            end else if (do_slide) begin
               bank_a[gi] <= bank_b[gi];
               bank_b[gi] <= bank_v[gi];
            end else if (do_sum && (pos == IDXW'(gi))) begin
               bank_v[gi] <= sum_dig;
            end
         end
      end
   endgenerate

   assign old_a    = bank_a[pos];
   assign old_b    = bank_b[pos];
   assign view_dig = bank_v[view_idx];
endmodule

// File: rtl/fib_bcd_engine.sv
module fib_bcd_engine #(
   parameter  int DIGITS      = 16,
   parameter  int NIB         = 4,
   parameter  int ADJ_VARIANT = 0,
   localparam int IDXW        = $clog2(DIGITS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            tick,
   input  logic [IDXW-1:0] rd_idx,
   output logic [NIB-1:0]  rd_digit,
   output logic            disp_valid
);
   generate
      if (NIB != 4) begin : g_bad_nib
         $error("fib_bcd_engine: NIB must be 4 for decimal digits");
      end
      if (DIGITS < 2 || (1 << IDXW) != DIGITS) begin : g_bad_digits
         $error("fib_bcd_engine: DIGITS must be a power of two, at least 2");
      end
      if (ADJ_VARIANT < 0 || ADJ_VARIANT > 1) begin : g_bad_variant
         $error("fib_bcd_engine: ADJ_VARIANT must be 0 or 1");
      end
   endgenerate

   logic            do_load, do_sum, do_slide;
   logic [IDXW-1:0] pos;
   logic            carry_q, dig_cout;
   logic [NIB-1:0]  dig_a, dig_b, dig_sum;

   fib_seq_ctrl #(.DIGITS(DIGITS)) u_ctrl (
      .clk(clk), .rst(rst), .tick(tick), .dig_carry(dig_cout),
      .do_load(do_load), .do_sum(do_sum), .do_slide(do_slide),
      .pos(pos), .carry_q(carry_q), .show(disp_valid)
   );

   fib_bank_regs #(.DIGITS(DIGITS), .NIB(NIB)) u_banks (
      .clk(clk), .rst(rst), .do_load(do_load), .do_slide(do_slide),
      .do_sum(do_sum), .pos(pos), .sum_dig(dig_sum),
      .old_a(dig_a), .old_b(dig_b),
      .view_idx(rd_idx), .view_dig(rd_digit)
   );

   bcd_digit_adder #(.NIB(NIB), .ADJ_VARIANT(ADJ_VARIANT)) u_add (
      .a_dig(dig_a), .b_dig(dig_b), .c_in(carry_q),
      .s_dig(dig_sum), .c_out(dig_cout)
   );
endmodule

// File: rtl/fib_bcd_engine_chk.sv
module fib_bcd_engine_chk #(
   parameter  int DIGITS = 16,
   parameter  int NIB    = 4,
   localparam int IDXW   = $clog2(DIGITS)
) (
   input logic            clk,
   input logic            rst,
   input logic            tick,
   input logic [IDXW-1:0] rd_idx,
   input logic [NIB-1:0]  rd_digit,
   input logic            disp_valid,
   input logic            add_en,
   input logic [NIB-1:0]  dig_a,
   input logic [NIB-1:0]  dig_b,
   input logic            dig_cin,
   input logic [NIB-1:0]  dig_sum,
   input logic            dig_cout
);
   logic [NIB:0] bin_sum;
   assign bin_sum = {1'b0, dig_a} + {1'b0, dig_b} + (NIB+1)'(dig_cin);

   p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !disp_valid)
      else $error("R1: display valid after reset cycle");

   p_digit_decimal_r2: assert property (@(posedge clk) disable iff (rst)
      (add_en && dig_a <= 9 && dig_b <= 9) |-> (dig_sum <= 9 && dig_cout == (bin_sum >= 10)))
      else $error("R2: digit not decimal-corrected");

   p_tick_drops_r4: assert property (@(posedge clk) disable iff (rst)
      (disp_valid && tick) |=> !disp_valid)
      else $error("R4: valid held after accepted tick");

   p_no_write_shown_r4: assert property (@(posedge clk) disable iff (rst)
      add_en |-> !disp_valid)
      else $error("R4: display bank written while valid");

   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (disp_valid && !tick) |=> disp_valid)
      else $error("R6: valid dropped without tick");

   p_stable_digit_r6: assert property (@(posedge clk) disable iff (rst)
      (disp_valid && $past(disp_valid) && $stable(rd_idx)) |-> $stable(rd_digit))
      else $error("R6: shown digit changed while valid");
endmodule

bind fib_bcd_engine fib_bcd_engine_chk #(.DIGITS(DIGITS), .NIB(NIB)) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .rd_idx(rd_idx), .rd_digit(rd_digit),
   .disp_valid(disp_valid), .add_en(do_sum), .dig_a(dig_a), .dig_b(dig_b),
   .dig_cin(carry_q), .dig_sum(dig_sum), .dig_cout(dig_cout)
);

// File: tb/fib_bcd_engine_bench.sv
`timescale 1ns/1ps
module fib_bcd_engine_bench;
   localparam int DIGITS = 16;
   localparam int NTAB   = 12;
   localparam longint unsigned LIMIT = 64'd10000000000000000;
   // expected display terms after ticks 1..12 (packed decimal)
   localparam logic [63:0] TERMS [NTAB] = '{
      64'h2, 64'h3, 64'h5, 64'h8, 64'h13, 64'h21,
      64'h34, 64'h55, 64'h89, 64'h144, 64'h233, 64'h377
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b0;
   logic [3:0] rd_idx = '0;
   logic [3:0] rd_digit;
   logic       disp_valid;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   fib_bcd_engine u_fib_bcd_engine (
      .clk(clk), .rst(rst), .tick(tick), .rd_idx(rd_idx),
      .rd_digit(rd_digit), .disp_valid(disp_valid)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] to_bcd(input longint unsigned v);
      logic [63:0] r = '0;
      longint unsigned t = v;
      for (int i = 0; i < DIGITS; i++) begin
         r[i*4 +: 4] = 4'(t % 10);
         t = t / 10;
      end
      return r;
   endfunction

   // reads all display digits inside one low clock phase (R8)
   task automatic read_all(output logic [63:0] v);
      @(negedge clk);
      v = '0;
      for (int i = 0; i < DIGITS; i++) begin
         rd_idx = 4'(i);
         #0.1;
         v[i*4 +: 4] = rd_digit;
      end
   endtask

   task automatic wait_valid(output int cnt);
      cnt = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (disp_valid) break;
         cnt++;
      end
   endtask

   task automatic pulse_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #800000;
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
   end

   initial begin
      logic [63:0] v;
      int cnt;
      longint unsigned fa, fb, fc;
      bit ovf;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!disp_valid, "R1 valid in reset", 64'(disp_valid), 64'h0);
      read_all(v);
      chk(v == 64'h0, "R1 digits in reset", v, 64'h0);
      @(negedge clk) rst = 1'b0;
      wait_valid(cnt);
      chk(cnt == DIGITS, "R4 first window", 64'(cnt), 64'(DIGITS));
      read_all(v);
      chk(v == 64'h1, "R1 first term", v, 64'h1);

      fa = 0; fb = 1; fc = 1;
      // vector walk (R3, R2, R4, R5)
      for (int i = 0; i < NTAB; i++) begin
         fa = fb; fb = fc; fc = fa + fb;
         pulse_tick();
         chk(!disp_valid, "R4 drop after tick", 64'(disp_valid), 64'h0);
         if (i == 5) begin
            // R5: second tick in the middle of the add
            pulse_tick();
            wait_valid(cnt);
            chk(cnt == DIGITS - 2, "R5 window with extra tick", 64'(cnt), 64'(DIGITS - 2));
         end else begin
            wait_valid(cnt);
            chk(cnt == DIGITS, "R4 window", 64'(cnt), 64'(DIGITS));
         end
         read_all(v);
         chk(v == TERMS[i], "R3 term", v, TERMS[i]);
         chk(v == to_bcd(fc), "R2 term model", v, to_bcd(fc));
         if (i == 5) begin
            // R6: held, unchanged, no tick
            repeat (6) @(negedge clk);
            chk(disp_valid, "R6 valid held", 64'(disp_valid), 64'h1);
            read_all(v);
            chk(v == TERMS[i], "R5 term not advanced", v, TERMS[i]);
         end
      end

      // R8: single digit of 377
      @(negedge clk) rd_idx = 4'd1;
      #0.1;
      chk(rd_digit == 4'd7, "R8 digit 1", 64'(rd_digit), 64'h7);
      rd_idx = 4'd2;
      #0.1;
      chk(rd_digit == 4'd3, "R8 digit 2", 64'(rd_digit), 64'h3);

      // long run to overflow (R2 carries of 16..19, R7 restart)
      for (int n = 0; n < 70; n++) begin
         fa = fb; fb = fc; fc = fa + fb;
         ovf = (fc >= LIMIT);
         if (ovf) begin fa = 0; fb = 1; fc = 1; end
         pulse_tick();
         wait_valid(cnt);
         if (ovf) begin
            chk(cnt == 2*DIGITS + 1, "R7 restart window", 64'(cnt), 64'(2*DIGITS + 1));
         end else begin
            chk(cnt == DIGITS, "R4 window long", 64'(cnt), 64'(DIGITS));
         end
         read_all(v);
         chk(v == to_bcd(fc), ovf ? "R7 restart value" : "R3 long term", v, to_bcd(fc));
      end

      // R1: reset in the middle of an add
      pulse_tick();
      @(negedge clk) rst = 1'b1;
      @(negedge clk);
      chk(!disp_valid, "R1 valid mid reset", 64'(disp_valid), 64'h0);
      read_all(v);
      chk(v == 64'h0, "R1 digits mid reset", v, 64'h0);
      @(negedge clk) rst = 1'b0;
      wait_valid(cnt);
      chk(cnt == DIGITS, "R4 window after reset", 64'(cnt), 64'(DIGITS));
      read_all(v);
      chk(v == 64'h1, "R1 term after reset", v, 64'h1);

      finish_run();
   end
endmodule